// File: doc/BRIEF.md
# Accumulator Machine Fetch-Execute Sequencer

This block is the controller and datapath of a small single-accumulator processor. It holds a 12-bit program counter and address register, and 16-bit instruction, data, accumulator and temporary registers. A step counter and a state register take each instruction through fixed register-transfer steps: fetch, decode, an optional indirect-address step, and execute. The step counter returns to zero when each instruction completes.

The block talks to an external word-addressed memory of 4096 sixteen-bit words. It has one address bus, a write strobe, write data, and read data that arrives one cycle after the address. The instruction word holds an indirect flag in bit 15, an operation code in bits 14:12 and an operand address in bits 11:0. The memory-reference operations combine a memory word with the accumulator. Operation code 7 stops the machine. At each instruction boundary the sequencer samples an interrupt request. If the request is present and interrupts are enabled, it saves the return address at word 0 and restarts fetching at word 1.

Top module: `acc_seq_core`

## Requirements
- R1: Synchronous active-high reset clears the program counter, the address register and the accumulator, sets the interrupt enable and deasserts `halted`. The first fetch after reset reads word 0.
- R2: A fetch takes four cycles. AR takes PC. Memory is read at AR and PC increments. DR takes the read word. IR takes DR. Decode follows in the fifth cycle.
- R3: Operation codes (bits 14:12) are 0 = AND (AC takes AC & operand), 1 = ADD, 2 = LOAD (AC takes operand), 3 = STORE, 4 = BRANCH, 5 and 6 = no operation, 7 = halt.
- R4: ADD sets AC to (AC + operand) modulo 2^16, and the carry out goes to a one-bit E flag.
- R5: STORE writes AC to the address held in AR in the sixth cycle of the instruction. A direct AND, ADD or LOAD takes 8 cycles. A direct STORE, BRANCH or no-op takes 6 cycles.
- R6: With bit 15 set, two extra cycles read the word at the address field and load AR with its low 12 bits (the upper 4 bits are ignored) before the operand step.
- R7: BRANCH loads PC with the effective address, so the next fetch comes from there.
- R8: Operation codes 5 and 6 change no register or memory word and complete in 6 cycles.
- R9: Operation code 7 raises `halted` in the cycle after decode. The machine then stays halted with no memory writes until reset.
- R10: When an instruction completes while `irq_req` is high and interrupts are enabled, two cycles follow. They write the return PC (zero-extended) to word 0, load PC with 1 and clear the enable. Fetch then resumes.
- R11: Once the enable is cleared, a held `irq_req` is ignored at later instruction boundaries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Word address for memory read or write |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| irq_req | input | 1 | Interrupt request, sampled at instruction boundaries |
| halted | output | 1 | High once a halt instruction has been decoded |

## Verification
The hardest situation to bring about is the interrupt boundary. A request has to be pending exactly when an instruction completes, and it then has to be masked for the rest of the run even though it stays asserted. The stimulus holds the request high from reset. The first boundary, after a branch, therefore takes the interrupt. The serviced routine then stores and halts. The cycles of the saved-PC write, the following store and the halt would all move if the request were taken a second time or at the wrong boundary.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int ADDR_W = 12;
    localparam int WORD_W = 16;
    localparam int STEP_W = 4;
    localparam int MAX_STEPS = 10;

    typedef enum logic [2:0] {
        OP_AND = 3'd0,
        OP_ADD = 3'd1,
        OP_LDA = 3'd2,
        OP_STA = 3'd3,
        OP_BRA = 3'd4,
        OP_NP5 = 3'd5,
        OP_NP6 = 3'd6,
        OP_HLT = 3'd7
    } opc_e;

    typedef struct packed {
        logic              ind;
        opc_e              op;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    typedef enum logic [3:0] {
        ST_F0, ST_F1, ST_F2, ST_F3, ST_DEC,
        ST_IND1, ST_IND2, ST_EX0, ST_EX1, ST_EX2,
        ST_INT0, ST_INT1, ST_HALT
    } step_e;

    typedef struct packed {
        logic ar_from_pc;
        logic ar_from_ir;
        logic ar_from_rd;
        logic ar_clr;
        logic pc_inc;
        logic pc_from_ar;
        logic pc_one;
        logic dr_from_rd;
        logic ir_from_dr;
        logic ac_load;
        logic tr_from_pc;
        logic wr_en;
        logic wr_sel_tr;
        logic ien_clr;
    } ctl_t;

    function automatic logic needs_operand(opc_e op);
        return (op == OP_AND) || (op == OP_ADD) || (op == OP_LDA);
    endfunction

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
(
    input  opc_e              op,
    input  logic [WORD_W-1:0] ac,
    input  logic [WORD_W-1:0] opnd,
    input  logic              e_in,
    output logic [WORD_W-1:0] ac_nx,
    output logic              e_nx
);
    logic [WORD_W:0] sum;

    always_comb begin
        sum   = {1'b0, ac} + {1'b0, opnd};
        ac_nx = ac;
        e_nx  = e_in;
        case (op)
            OP_AND: ac_nx = ac & opnd;
            OP_ADD: begin
                ac_nx = sum[WORD_W-1:0];
                e_nx  = sum[WORD_W];
            end
            OP_LDA: ac_nx = opnd;
            default: ;
        endcase
    end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
    import acc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ind,
    input  opc_e  op,
    input  logic  irq_req,
    input  logic  ien,
    output step_e state,
    output ctl_t  ctl,
    output logic  halted
);
    step_e             nxt;
    logic              done;
    logic [STEP_W-1:0] sc;

    always_comb begin
        ctl  = '0;
        nxt  = state;
        done = 1'b0;
        case (state)
            ST_F0:   begin ctl.ar_from_pc = 1'b1; nxt = ST_F1; end
            ST_F1:   begin ctl.pc_inc     = 1'b1; nxt = ST_F2; end
            ST_F2:   begin ctl.dr_from_rd = 1'b1; nxt = ST_F3; end
            ST_F3:   begin ctl.ir_from_dr = 1'b1; nxt = ST_DEC; end
            ST_DEC: begin
                ctl.ar_from_ir = 1'b1;
                if (op == OP_HLT) nxt = ST_HALT;
                else if (ind)     nxt = ST_IND1;
                else              nxt = ST_EX0;
            end
            ST_IND1: nxt = ST_IND2;
            ST_IND2: begin ctl.ar_from_rd = 1'b1; nxt = ST_EX0; end
            ST_EX0: begin
                if (needs_operand(op)) nxt = ST_EX1;
                else                   done = 1'b1;
                if (op == OP_STA) ctl.wr_en      = 1'b1;
                if (op == OP_BRA) ctl.pc_from_ar = 1'b1;
            end
            ST_EX1:  begin ctl.dr_from_rd = 1'b1; nxt = ST_EX2; end
            ST_EX2:  begin ctl.ac_load = 1'b1; done = 1'b1; end
            ST_INT0: begin ctl.ar_clr = 1'b1; ctl.tr_from_pc = 1'b1; nxt = ST_INT1; end
            ST_INT1: begin
                ctl.wr_en     = 1'b1;
                ctl.wr_sel_tr = 1'b1;
                ctl.pc_one    = 1'b1;
                ctl.ien_clr   = 1'b1;
                nxt           = ST_F0;
            end
            default: nxt = ST_HALT;
        endcase
        if (done) nxt = (irq_req && ien) ? ST_INT0 : ST_F0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_F0;
            sc    <= '0;
        end else begin
            state <= nxt;
            if (nxt == ST_F0 || nxt == ST_INT0 || state == ST_HALT) sc <= '0;
            else                                                     sc <= sc + 1'b1;
        end
    end

    assign halted = (state == ST_HALT);

    // R2: every fetch begins with the step counter at zero
    p_fetch_sc_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_F0) |-> (sc == '0));
    // R6: no instruction, even indirect, runs past the longest step sequence
    p_sc_bound_r6: assert property (@(posedge clk) disable iff (rst)
        (sc < STEP_W'(MAX_STEPS)));
    // R9: halt is sticky and silent
    p_halt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && !ctl.wr_en));
endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              irq_req,
    output logic              halted
);
    logic [ADDR_W-1:0] pc, ar;
    instr_t            ir;
    logic [WORD_W-1:0] dr, ac, tr, alu_ac;
    logic              e_flag, alu_e, ien;
    step_e             state;
    ctl_t              ctl;

    acc_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ind     (ir.ind),
        .op      (ir.op),
        .irq_req (irq_req),
        .ien     (ien),
        .state   (state),
        .ctl     (ctl),
        .halted  (halted)
    );

    acc_alu u_alu (
        .op    (ir.op),
        .ac    (ac),
        .opnd  (dr),
        .e_in  (e_flag),
        .ac_nx (alu_ac),
        .e_nx  (alu_e)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            ar     <= '0;
            ir     <= '0;
            dr     <= '0;
            ac     <= '0;
            tr     <= '0;
            e_flag <= 1'b0;
            ien    <= 1'b1;
        end else begin
            if (ctl.ar_from_pc) ar <= pc;
            if (ctl.ar_from_ir) ar <= ir.addr;
            if (ctl.ar_from_rd) ar <= mem_rdata[ADDR_W-1:0];
            if (ctl.ar_clr)     ar <= '0;
            if (ctl.pc_inc)     pc <= pc + 1'b1;
            if (ctl.pc_from_ar) pc <= ar;
            if (ctl.pc_one)     pc <= ADDR_W'(1);
            if (ctl.dr_from_rd) dr <= mem_rdata;
            if (ctl.ir_from_dr) ir <= instr_t'(dr);
            if (ctl.ac_load) begin
                ac     <= alu_ac;
                e_flag <= alu_e;
            end
            if (ctl.tr_from_pc) tr <= WORD_W'(pc);
            if (ctl.ien_clr)    ien <= 1'b0;
        end
    end

    assign mem_addr  = ar;
    assign mem_we    = ctl.wr_en;
    assign mem_wdata = ctl.wr_sel_tr ? tr : ac;

    // R2: PC advances by one during the memory-read step of fetch
    p_pc_inc_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_F1) |=> (pc == $past(pc) + 1'b1));
    // R10: interrupt entry leaves PC at 1 with the enable cleared
    p_int_vector_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INT1) |=> ((pc == ADDR_W'(1)) && !ien));
    // R11: once cleared, the enable stays cleared until reset
    p_ien_stays_r11: assert property (@(posedge clk) disable iff (rst)
        !ien |=> !ien);
    // R10: the interrupt write targets word 0
    p_int_addr_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_INT1) |-> (mem_we && (mem_addr == '0)));
endmodule

// File: tb/acc_seq_core_tb_top.sv
`timescale 1ns/1ps
module acc_seq_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq_req = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] rd_q;
    logic        halted;

    logic [15:0] mem [0:4095];
    logic        tb_we = 1'b0;
    logic [11:0] tb_addr = '0;
    logic [15:0] tb_data = '0;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;

    logic [11:0] q_addr[$];
    logic [15:0] q_data[$];
    int          q_cyc[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    acc_seq_core dut_i (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (rd_q),
        .irq_req   (irq_req),
        .halted    (halted)
    );

    always @(posedge clk) begin
        if (tb_we) mem[tb_addr] <= tb_data;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
        rd_q <= mem[mem_addr];
    end

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [11:0] a, input logic [15:0] d);
        tb_addr = a;
        tb_data = d;
        tb_we   = 1'b1;
        @(negedge clk);
        tb_we   = 1'b0;
    endtask

    task automatic expect_wr(input logic [11:0] a, input logic [15:0] d, input int c, input string tag);
        q_addr.push_back(a);
        q_data.push_back(d);
        q_cyc.push_back(c);
        q_tag.push_back(tag);
    endtask

    // scoreboard monitor: compares every write the design makes
    always @(negedge clk) begin
        if (!rst && mem_we) begin
            if (q_addr.size() == 0) begin
                check(1'b0, "R11 unexpected write addr", int'(mem_addr), 0);
            end else begin
                logic [11:0] ea;
                logic [15:0] ed;
                int          ec;
                string       et;
                ea = q_addr.pop_front();
                ed = q_data.pop_front();
                ec = q_cyc.pop_front();
                et = q_tag.pop_front();
                check(mem_addr == ea, {et, " addr"}, int'(mem_addr), int'(ea));
                check(mem_wdata == ed, {et, " data"}, int'(mem_wdata), int'(ed));
                check(cyc == ec, {et, " cycle"}, cyc, ec);
            end
        end
    end

    task automatic run_to_halt(input int exp_cyc, input string tag);
        int t;
        t = 0;
        while (!halted && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(halted, {tag, " watchdog"}, int'(halted), 1);
        check(cyc == exp_cyc, {tag, " halt cycle"}, cyc, exp_cyc);
    endtask

    initial begin
        @(negedge clk);
        // program 1: all memory-reference operations
        poke(12'h000, 16'h4020);   // BRANCH 0x020
        poke(12'h020, 16'h2100);   // LOAD 0x100
        poke(12'h021, 16'h3200);   // STORE 0x200
        poke(12'h022, 16'h0101);   // AND 0x101
        poke(12'h023, 16'h3201);   // STORE 0x201
        poke(12'h024, 16'h2102);   // LOAD 0x102
        poke(12'h025, 16'h1103);   // ADD 0x103
        poke(12'h026, 16'h3202);   // STORE 0x202
        poke(12'h027, 16'hA104);   // LOAD indirect via 0x104
        poke(12'h028, 16'hB105);   // STORE indirect via 0x105
        poke(12'h029, 16'h5000);   // no-op 5
        poke(12'h02A, 16'h6000);   // no-op 6
        poke(12'h02B, 16'hC106);   // BRANCH indirect via 0x106
        poke(12'h02C, 16'h32FF);   // skipped STORE
        poke(12'h030, 16'h1100);   // ADD 0x100
        poke(12'h031, 16'h3204);   // STORE 0x204
        poke(12'h032, 16'h7000);   // halt
        poke(12'h100, 16'h00FF);
        poke(12'h101, 16'h0F0F);
        poke(12'h102, 16'hFFFF);
        poke(12'h103, 16'h0001);
        poke(12'h104, 16'hF101);
        poke(12'h105, 16'hE203);
        poke(12'h106, 16'h0030);
        poke(12'h2FF, 16'hBEEF);

        check(halted == 1'b0, "R1 halted in reset", int'(halted), 0);
        check(mem_we == 1'b0, "R1 no write in reset", int'(mem_we), 0);

        expect_wr(12'h200, 16'h00FF, 19,  "R5 LOAD/STORE");
        expect_wr(12'h201, 16'h000F, 33,  "R3 AND");
        expect_wr(12'h202, 16'h0000, 55,  "R4 ADD wrap");
        expect_wr(12'h203, 16'h0F0F, 73,  "R6 indirect");
        expect_wr(12'h204, 16'h100E, 107, "R7 R8 branch and no-op");

        rst = 1'b0;
        run_to_halt(113, "R9");
        repeat (20) @(negedge clk);
        check(halted, "R9 halt sticky", int'(halted), 1);
        check(q_addr.size() == 0, "R5 all stores seen", q_addr.size(), 0);
        check(mem[12'h2FF] == 16'hBEEF, "R7 skipped word intact", int'(mem[12'h2FF]), 16'hBEEF);
        check(mem[12'h203] == 16'h0F0F, "R6 indirect target", int'(mem[12'h203]), 16'h0F0F);

        // program 2: interrupt held high from reset
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(halted == 1'b0, "R1 reset clears halt", int'(halted), 0);
        poke(12'h000, 16'h4020);   // BRANCH 0x020
        poke(12'h001, 16'h3210);   // STORE 0x210 (AC = 0)
        poke(12'h002, 16'h7000);   // halt
        irq_req = 1'b1;
        expect_wr(12'h000, 16'h0020, 7,  "R10 saved PC");
        expect_wr(12'h210, 16'h0000, 13, "R10 resume at 1");
        rst = 1'b0;
        run_to_halt(19, "R11");
        repeat (20) @(negedge clk);
        check(q_addr.size() == 0, "R10 all writes seen", q_addr.size(), 0);
        check(mem[12'h000] == 16'h0020, "R10 word 0", int'(mem[12'h000]), 16'h0020);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule